// File: doc/BRIEF.md
# Overflow-Flag Carry-Chain Adder

This execution stage adds a destination register value, a source operand and a carry-in, and returns the sum together with an updated flag word. The carry-in is not taken from the usual carry flag. It comes from the overflow flag (bit 11 of the flag word), and the carry out of the sum is written back to that same bit. The carry flag stays free, so a second, independent carry chain can run alongside this one in multi-precision arithmetic. Software starts such a chain by clearing the overflow flag. Each word addition then passes its carry to the next one through the flag word.

Each cycle the stage takes one pre-split instruction record: the four opcode bytes, the two register fields of the ModRM byte, the REX bits, a lock-prefix marker and a 64-bit-mode indication. It recognises its own opcode, picks the full or half operand width, and forms the register indices. If a lock prefix is present or the feature enable is low, it raises an invalid-opcode fault and suppresses every write. Results appear one clock after the record is accepted.

Top module: `ovf_chain_adder`

## Requirements
- R1: In full-width operation, `res_val` equals (`dst_val` + `src_val` + `flags_in[11]`) modulo 2^DATA_W, and `flags_out[11]` equals the carry out of bit DATA_W-1.
- R2: In half-width operation, the low HALF_W bits of `res_val` are the sum of the low HALF_W bits of both operands plus `flags_in[11]`, `flags_out[11]` is the carry out of bit HALF_W-1, and bits DATA_W-1..HALF_W of `res_val` are zero.
- R3: Every bit of `flags_out` other than bit 11 equals the same bit of `flags_in`. This includes carry (bit 0), parity (bit 2), auxiliary carry (bit 4), zero (bit 6) and sign (bit 7).
- R4: A record is accepted only when `in_valid` is 1 and `opc` equals 32'hF30F38F6, with the first byte in bits 31:24. Any other record leaves `out_valid`, `res_we`, `flags_we` and `ud_fault` at 0 in the following cycle.
- R5: Full width is selected only when `long_mode`, `rex_present` and `rex_w` are all 1. Every other combination gives half width. `wide_op` reports the width that was used.
- R6: `dst_idx` is {`rex_r`, `reg_fld`} and `src_idx` is {`rex_b`, `rm_fld`} when `long_mode` and `rex_present` are both 1. Otherwise the top index bit is 0.
- R7: An accepted record with `lock_pfx` = 1 or `feat_en` = 0 drives `ud_fault` to 1 and holds `res_we` and `flags_we` at 0.
- R8: An accepted record without a fault drives `out_valid`, `res_we` and `flags_we` to 1 exactly one clock later.
- R9: While `rst_n` is low, every output is 0.
- R10: A chain of word additions that starts with `flags_in[11]` = 0, and feeds each `flags_out[11]` into the next word's `flags_in[11]`, produces the multi-word sum, with the final carry in bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction record present |
| opc | input | 32 | Four opcode bytes, first byte in bits 31:24 |
| reg_fld | input | 3 | ModRM reg field (destination) |
| rm_fld | input | 3 | ModRM r/m field (source) |
| rex_present | input | 1 | A REX prefix was decoded |
| rex_w | input | 1 | REX width-promotion bit |
| rex_r | input | 1 | REX destination-index extension bit |
| rex_b | input | 1 | REX source-index extension bit |
| lock_pfx | input | 1 | Lock prefix present |
| long_mode | input | 1 | Core is in 64-bit mode |
| feat_en | input | 1 | Feature enable |
| dst_val | input | DATA_W | Destination register value |
| src_val | input | DATA_W | Source operand value |
| flags_in | input | 32 | Current flag word |
| out_valid | output | 1 | Accepted record result present |
| res_val | output | DATA_W | New destination value |
| res_we | output | 1 | Destination write enable |
| dst_idx | output | 4 | Destination register index |
| src_idx | output | 4 | Source register index |
| wide_op | output | 1 | Full-width operation was used |
| flags_out | output | 32 | Updated flag word |
| flags_we | output | 1 | Flag write enable |
| ud_fault | output | 1 | Invalid-opcode fault |

## Verification
The bench builds the stage with DATA_W = 8 and HALF_W = 4. At that size every full-width operand pair can be swept with both carry-in values, and every half-width pair can be swept with varied upper bits in the destination. The carry-out boundary of each width, and the zeroing of the upper half, are therefore covered completely rather than sampled. The same small width lets the bench run four-word chains whose total is a 32-bit reference sum, so the carry hand-off through bit 11 is checked over many words.

// File: rtl/ovf_chain_adder.sv
module ovf_chain_adder #(
  parameter int          DATA_W  = 64,
  parameter int          HALF_W  = 32,
  parameter logic [31:0] OPC_SEQ = 32'hF30F38F6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       opc,
  input  logic [2:0]        reg_fld,
  input  logic [2:0]        rm_fld,
  input  logic              rex_present,
  input  logic              rex_w,
  input  logic              rex_r,
  input  logic              rex_b,
  input  logic              lock_pfx,
  input  logic              long_mode,
  input  logic              feat_en,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [31:0]       flags_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] res_val,
  output logic              res_we,
  output logic [3:0]        dst_idx,
  output logic [3:0]        src_idx,
  output logic              wide_op,
  output logic [31:0]       flags_out,
  output logic              flags_we,
  output logic              ud_fault
);
  localparam int OF_BIT = 11;
  localparam int UP_W   = DATA_W - HALF_W;

  logic              hit, fault, rex_ok, wide, cin, cout;
  logic [DATA_W:0]   sum_w;
  logic [HALF_W:0]   sum_n;
  logic [DATA_W-1:0] res_nx;
  logic [31:0]       flg_nx;

  assign hit    = in_valid && (opc == OPC_SEQ);
  assign fault  = lock_pfx || !feat_en;
  assign rex_ok = long_mode && rex_present;
  assign wide   = rex_ok && rex_w;
  assign cin    = flags_in[OF_BIT];

  assign sum_w  = {1'b0, dst_val} + {1'b0, src_val} + {{DATA_W{1'b0}}, cin};
  assign sum_n  = {1'b0, dst_val[HALF_W-1:0]} + {1'b0, src_val[HALF_W-1:0]}
                + {{HALF_W{1'b0}}, cin};
  assign res_nx = wide ? sum_w[DATA_W-1:0] : {{UP_W{1'b0}}, sum_n[HALF_W-1:0]};
  assign cout   = wide ? sum_w[DATA_W] : sum_n[HALF_W];

  always_comb begin
    flg_nx         = flags_in;
    flg_nx[OF_BIT] = cout;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_we    <= 1'b0;
      flags_we  <= 1'b0;
      ud_fault  <= 1'b0;
      res_val   <= '0;
      flags_out <= '0;
      dst_idx   <= '0;
      src_idx   <= '0;
      wide_op   <= 1'b0;
    end else begin
      out_valid <= hit;
      res_we    <= hit && !fault;
      flags_we  <= hit && !fault;
      ud_fault  <= hit && fault;
      if (hit) begin
        res_val   <= res_nx;
        flags_out <= flg_nx;
        dst_idx   <= {rex_ok && rex_r, reg_fld};
        src_idx   <= {rex_ok && rex_b, rm_fld};
        wide_op   <= wide;
      end
    end
  end

  AST_FAULT_BLOCKS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> (!res_we && !flags_we)); // R7
  AST_WRITES_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we || flags_we || ud_fault) |-> out_valid); // R8
  AST_VALID_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(in_valid) && $past(opc) == OPC_SEQ)); // R4
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && !wide_op) |-> (res_val[DATA_W-1:HALF_W] == '0)); // R2
  AST_WIDE_NEEDS_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wide_op) |-> ($past(long_mode) && $past(rex_present))); // R5
  AST_OTHER_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> ((flags_out & ~(32'h1 << OF_BIT)) ==
                  ($past(flags_in) & ~(32'h1 << OF_BIT)))); // R3
  AST_WIDE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && wide_op) |-> ({flags_out[OF_BIT], res_val} ==
      ({1'b0, $past(dst_val)} + {1'b0, $past(src_val)} +
       {{DATA_W{1'b0}}, $past(flags_in[OF_BIT])}))); // R1
endmodule

// File: tb/ovf_chain_adder_tb_top.sv
`timescale 1ns/1ps
module ovf_chain_adder_tb_top;
  localparam int DW = 8;
  localparam int HW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [31:0]   opc = '0;
  logic [2:0]    reg_fld = '0, rm_fld = '0;
  logic          rex_present = 1'b0, rex_w = 1'b0, rex_r = 1'b0, rex_b = 1'b0;
  logic          lock_pfx = 1'b0, long_mode = 1'b0, feat_en = 1'b0;
  logic [DW-1:0] dst_val = '0, src_val = '0;
  logic [31:0]   flags_in = '0;
  logic          out_valid, res_we, wide_op, flags_we, ud_fault;
  logic [DW-1:0] res_val;
  logic [3:0]    dst_idx, src_idx;
  logic [31:0]   flags_out;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ovf_chain_adder #(.DATA_W(DW), .HALF_W(HW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opc(opc),
    .reg_fld(reg_fld), .rm_fld(rm_fld), .rex_present(rex_present),
    .rex_w(rex_w), .rex_r(rex_r), .rex_b(rex_b), .lock_pfx(lock_pfx),
    .long_mode(long_mode), .feat_en(feat_en), .dst_val(dst_val),
    .src_val(src_val), .flags_in(flags_in), .out_valid(out_valid),
    .res_val(res_val), .res_we(res_we), .dst_idx(dst_idx), .src_idx(src_idx),
    .wide_op(wide_op), .flags_out(flags_out), .flags_we(flags_we),
    .ud_fault(ud_fault));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic base();
    in_valid = 1'b1; opc = 32'hF30F38F6; lock_pfx = 1'b0; feat_en = 1'b1;
    long_mode = 1'b1; rex_present = 1'b1; rex_w = 1'b1; rex_r = 1'b0; rex_b = 1'b0;
    reg_fld = 3'd0; rm_fld = 3'd0;
  endtask

  task automatic check_sum(input bit wide, input int a, input int b, input int c,
                           input logic [31:0] fl);
    int e;
    int er;
    int eo;
    logic [31:0] ef;
    if (wide) begin e = a + b + c; er = e & 255; eo = (e >> 8) & 1; end
    else begin e = (a & 15) + (b & 15) + c; er = e & 15; eo = (e >> 4) & 1; end
    ef = fl; ef[11] = eo[0];
    if (wide) chk(res_val == DW'(er), "R1 sum", res_val, er);
    else      chk(res_val == DW'(er), "R2 half sum/upper zero", res_val, er);
    chk(flags_out[11] == eo[0], wide ? "R1 carry" : "R2 carry", flags_out[11], eo);
    chk(flags_out == ef, "R3 other flags", flags_out, ef);
    chk(wide_op == wide, "R5 width", wide_op, wide);
  endtask

  initial begin
    #(1_900_000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] fl;
    base();
    dst_val = 8'hFF; src_val = 8'h01;
    repeat (3) step();
    chk({out_valid, res_we, flags_we, ud_fault, wide_op} == '0, "R9 reset ctl",
        {out_valid, res_we, flags_we, ud_fault, wide_op}, 0);
    chk(res_val == '0 && flags_out == '0 && dst_idx == '0 && src_idx == '0,
        "R9 reset data", {res_val, flags_out}, 0);
    rst_n = 1'b1;

    // R1, R3, R8: exhaustive full-width sweep
    base();
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++) begin
          fl = {a[7:0], b[7:0], b[7:0] ^ 8'h5A, a[7:0]};
          fl[11] = c[0];
          dst_val = a[7:0]; src_val = b[7:0]; flags_in = fl;
          step();
          chk(out_valid && res_we && flags_we && !ud_fault, "R8 valid/we",
              {out_valid, res_we, flags_we, ud_fault}, 4'b1110);
          check_sum(1'b1, a, b, c, fl);
        end

    // R2, R5: half-width sweep, upper destination bits varied
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++) begin
          base();
          case ((a + b) % 3)
            0: long_mode = 1'b0;
            1: rex_present = 1'b0;
            default: rex_w = 1'b0;
          endcase
          fl = ~{b[7:0], a[7:0], a[7:0], b[7:0]};
          fl[11] = c[0];
          dst_val = a[7:0]; src_val = {b[3:0] ^ 4'hA, b[3:0]}; flags_in = fl;
          step();
          check_sum(1'b0, a, b, c, fl);
        end

    // R5: rex_w outside 64-bit mode stays half width
    base(); long_mode = 1'b0; dst_val = 8'hF0; src_val = 8'h10; flags_in = 32'h0;
    step();
    chk(wide_op == 1'b0 && res_val == 8'h00 && flags_out[11] == 1'b0,
        "R5 no promotion outside long mode", {wide_op, res_val}, 0);

    // R6: register index formation
    for (int r = 0; r < 8; r++)
      for (int m = 0; m < 8; m++)
        for (int x = 0; x < 8; x++) begin
          base();
          reg_fld = r[2:0]; rm_fld = m[2:0];
          rex_r = x[0]; rex_b = x[1];
          if (x[2]) long_mode = 1'b0;
          step();
          chk(dst_idx == {x[0] & ~x[2], r[2:0]}, "R6 dst_idx", dst_idx,
              {x[0] & ~x[2], r[2:0]});
          chk(src_idx == {x[1] & ~x[2], m[2:0]}, "R6 src_idx", src_idx,
              {x[1] & ~x[2], m[2:0]});
        end
    for (int x = 0; x < 2; x++) begin
      base(); rex_present = 1'b0; rex_r = 1'b1; rex_b = 1'b1; reg_fld = 3'd5;
      rm_fld = 3'd2; long_mode = x[0];
      step();
      chk(dst_idx == 4'd5 && src_idx == 4'd2, "R6 no rex no extension",
          {dst_idx, src_idx}, 8'h52);
    end

    // R7: fault cases
    for (int k = 0; k < 3; k++) begin
      base();
      lock_pfx = (k != 1); feat_en = (k == 0);
      dst_val = 8'hFF; src_val = 8'hFF; flags_in = 32'h800;
      step();
      chk(out_valid && ud_fault && !res_we && !flags_we, "R7 fault blocks writes",
          {out_valid, ud_fault, res_we, flags_we}, 4'b1100);
    end

    // R4: non-matching records and idle cycles
    for (int k = 0; k < 5; k++) begin
      base();
      if (k < 4) opc = opc ^ (32'h01 << (8 * k));
      else in_valid = 1'b0;
      step();
      chk({out_valid, res_we, flags_we, ud_fault} == 4'b0000, "R4 not accepted",
          {out_valid, res_we, flags_we, ud_fault}, 0);
    end
    base(); lock_pfx = 1'b1; opc = 32'hF20F38F6;
    step();
    chk(ud_fault == 1'b0 && out_valid == 1'b0, "R4 no fault on other opcode",
        {out_valid, ud_fault}, 0);

    // R10: four-word chains against a 32-bit reference
    for (int t = 0; t < 6; t++) begin
      logic [31:0] va, vb, acc;
      logic [32:0] ref_sum;
      logic        of;
      case (t)
        0: begin va = 32'hFFFFFFFF; vb = 32'h00000001; end
        1: begin va = 32'h12345678; vb = 32'h9ABCDEF0; end
        2: begin va = 32'h80000000; vb = 32'h80000000; end
        3: begin va = 32'h00FF00FF; vb = 32'h00010001; end
        4: begin va = 32'hFFFFFFFF; vb = 32'hFFFFFFFF; end
        default: begin va = 32'h0; vb = 32'h0; end
      endcase
      ref_sum = {1'b0, va} + {1'b0, vb};
      of = 1'b0; acc = '0;
      base();
      for (int w = 0; w < 4; w++) begin
        dst_val = va[8*w +: 8]; src_val = vb[8*w +: 8];
        flags_in = 32'h0000_00C5; flags_in[11] = of;
        step();
        acc[8*w +: 8] = res_val;
        of = flags_out[11];
      end
      chk({of, acc} == ref_sum, "R10 chained sum", {of, acc}, ref_sum);
    end

    in_valid = 1'b0;
    step();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule